// File: doc/BRIEF.md
# Pointer Register Address Unit

This unit keeps three 16-bit address pointers, each built by joining two 8-bit general registers, and turns them into data-memory addresses for indirect loads and stores. Each access names one pointer and one of four modes:
- plain indirect, where the pointer is the address;
- offset, where a 6-bit unsigned offset is added to the pointer;
- decrement-before-use;
- increment-after-use.

The unit drives the effective address and the pointer value to be written back. It stores that value at the next clock edge when the mode changes the pointer. Increment-after-use on the third pointer also serves reads of constants from program memory, where that pointer holds a byte address.

The register file loads either byte of any pointer through an 8-bit write port addressed by register number. The low byte of each pair sits at the even register number and the high byte at the odd one above it. A byte write and a pointer writeback may hit the same pointer in one cycle. When that happens, the byte write owns the byte it targets and the writeback supplies the other byte. Illegal requests are reported on a flag and change nothing.

Top module: `ptr_addr_unit`

## Requirements
- R1: After reset all three pointers read 0 on `x_ptr`, `y_ptr` and `z_ptr`.
- R2: A byte write (`wr_en`=1) loads `wr_data` into one byte, chosen by `wr_idx`:
  - index 26 is the low byte and 27 the high byte of pointer X;
  - 28 and 29 are the low and high bytes of Y;
  - 30 and 31 are the low and high bytes of Z;
  - any other index changes no pointer.
- R3: With `acc_valid`=1 and mode code 0 (plain), `eff_addr` equals the selected pointer, `upd_ptr` equals the pointer, and the pointer is unchanged. Selector codes are 0=X, 1=Y, 2=Z.
- R4: Mode code 1 (offset) on Y or Z gives `eff_addr` = pointer + zero-extended `acc_disp` (0..63), modulo 2^16, and leaves the pointer unchanged.
- R5: Mode code 2 (decrement-before-use) gives `eff_addr` = `upd_ptr` = pointer − 1 modulo 2^16 (0 becomes 0xFFFF), and the pointer takes that value.
- R6: Mode code 3 (increment-after-use) gives `eff_addr` = pointer and `upd_ptr` = pointer + 1 modulo 2^16 (0xFFFF becomes 0), and the pointer takes that value. This includes Z when it is used for constant reads.
- R7: `acc_illegal` is 1 exactly when `acc_valid`=1 and either the offset mode is requested on X or the selector code is 3. An illegal access drives `eff_addr`=0, drives `upd_ptr` with the selected pointer (0 for code 3), and updates no pointer.
- R8: A pointer written back by an access shows its new value one clock after the strobe, so back-to-back accesses chain. With `acc_valid`=0 no pointer changes and `acc_illegal` is 0.
- R9: If a byte write and a writeback target the same pointer in one cycle, the written byte takes `wr_data` and the other byte takes the written-back value. A byte write to a different pointer in the same cycle takes effect alongside the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe |
| acc_sel | input | 2 | Pointer selector: 0=X, 1=Y, 2=Z, 3 illegal |
| acc_mode | input | 2 | 0 plain, 1 offset, 2 decrement-before-use, 3 increment-after-use |
| acc_disp | input | 6 | Unsigned offset for mode 1 |
| wr_en | input | 1 | Byte write enable from the register file |
| wr_idx | input | 5 | Register number of the byte write |
| wr_data | input | 8 | Byte write data |
| eff_addr | output | 16 | Effective data-memory address |
| upd_ptr | output | 16 | Pointer value to be written back |
| acc_illegal | output | 1 | Illegal access request |
| x_ptr | output | 16 | Current pointer X |
| y_ptr | output | 16 | Current pointer Y |
| z_ptr | output | 16 | Current pointer Z |

## Verification
The two functions that can fall in one cycle are a byte write from the register file and the writeback of a pointer-changing access. The bench provokes this by strobing increment-after-use and decrement-before-use accesses while writing a byte of the same pointer. It also pairs a writeback on one pointer with a byte write to another. The bench judges each case by comparing the pointer one clock later against a merged value: the written byte from `wr_data`, and the other byte from the incremented or decremented pointer.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;

    localparam int NUM_PTR   = 3;
    localparam int PAIR_BASE = 26;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_DISP    = 2'd1,
        MODE_PREDEC  = 2'd2,
        MODE_POSTINC = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        SEL_X    = 2'd0,
        SEL_Y    = 2'd1,
        SEL_Z    = 2'd2,
        SEL_NONE = 2'd3
    } ptr_sel_e;

endpackage

// File: rtl/ptr_pair_reg.sv
module ptr_pair_reg #(
    parameter int BYTE_W    = 8,
    parameter int REG_IDX_W = 5,
    parameter int LO_IDX    = 26
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_en,
    input  logic [2*BYTE_W-1:0]    upd_val,
    input  logic                   wr_en,
    input  logic [REG_IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [2*BYTE_W-1:0]    q
);
    localparam logic [REG_IDX_W-1:0] IDX_LO = REG_IDX_W'(LO_IDX);
    localparam logic [REG_IDX_W-1:0] IDX_HI = REG_IDX_W'(LO_IDX + 1);

    logic [2*BYTE_W-1:0] nxt;

    // writeback first, then the byte write overrides its own byte (R9)
    always_comb begin
        nxt = upd_en ? upd_val : q;
        if (wr_en && (wr_idx == IDX_LO)) nxt[BYTE_W-1:0] = wr_data;
        if (wr_en && (wr_idx == IDX_HI)) nxt[2*BYTE_W-1:BYTE_W] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_addr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic                 acc_valid,
    input  logic [1:0]           acc_sel,
    input  logic [1:0]           acc_mode,
    input  logic [DISP_W-1:0]    acc_disp,
    input  logic [ADDR_W-1:0]    ptr_x,
    input  logic [ADDR_W-1:0]    ptr_y,
    input  logic [ADDR_W-1:0]    ptr_z,
    output logic [ADDR_W-1:0]    eff_addr,
    output logic [ADDR_W-1:0]    upd_ptr,
    output logic                 acc_illegal,
    output logic [NUM_PTR-1:0]   upd_en
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    acc_mode_e           mode;
    ptr_sel_e            sel;
    logic [ADDR_W-1:0]   base;
    logic                bad_req;
    logic                commit;

    assign mode = acc_mode_e'(acc_mode);
    assign sel  = ptr_sel_e'(acc_sel);

    always_comb begin
        unique case (sel)
            SEL_X:   base = ptr_x;
            SEL_Y:   base = ptr_y;
            SEL_Z:   base = ptr_z;
            default: base = '0;
        endcase
    end

    assign bad_req     = (sel == SEL_NONE) || ((sel == SEL_X) && (mode == MODE_DISP));
    assign acc_illegal = acc_valid && bad_req;

    always_comb begin
        eff_addr = base;
        upd_ptr  = base;
        unique case (mode)
            MODE_PLAIN:   ;
            MODE_DISP:    eff_addr = base + {{(ADDR_W-DISP_W){1'b0}}, acc_disp};
            MODE_PREDEC:  begin
                eff_addr = base - ONE;
                upd_ptr  = base - ONE;
            end
            MODE_POSTINC: upd_ptr = base + ONE;
        endcase
        if (bad_req) begin
            eff_addr = '0;
            upd_ptr  = base;
        end
    end

    assign commit = acc_valid && !bad_req &&
                    ((mode == MODE_PREDEC) || (mode == MODE_POSTINC));

    always_comb begin
        upd_en = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (commit && (acc_sel == 2'(i))) upd_en[i] = 1'b1;
        end
    end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import ptr_addr_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DISP_W    = 6,
    parameter int REG_IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [1:0]              acc_sel,
    input  logic [1:0]              acc_mode,
    input  logic [DISP_W-1:0]       acc_disp,
    input  logic                    wr_en,
    input  logic [REG_IDX_W-1:0]    wr_idx,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [2*BYTE_W-1:0]     eff_addr,
    output logic [2*BYTE_W-1:0]     upd_ptr,
    output logic                    acc_illegal,
    output logic [2*BYTE_W-1:0]     x_ptr,
    output logic [2*BYTE_W-1:0]     y_ptr,
    output logic [2*BYTE_W-1:0]     z_ptr
);
    localparam int ADDR_W = 2 * BYTE_W;

    logic [ADDR_W-1:0]  ptr_q [NUM_PTR];
    logic [NUM_PTR-1:0] upd_en;

    ptr_agu #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agu (
        .acc_valid   (acc_valid),
        .acc_sel     (acc_sel),
        .acc_mode    (acc_mode),
        .acc_disp    (acc_disp),
        .ptr_x       (ptr_q[0]),
        .ptr_y       (ptr_q[1]),
        .ptr_z       (ptr_q[2]),
        .eff_addr    (eff_addr),
        .upd_ptr     (upd_ptr),
        .acc_illegal (acc_illegal),
        .upd_en      (upd_en)
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_pair
        ptr_pair_reg #(
            .BYTE_W    (BYTE_W),
            .REG_IDX_W (REG_IDX_W),
            .LO_IDX    (PAIR_BASE + 2 * i)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_en[i]),
            .upd_val (upd_ptr),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .q       (ptr_q[i])
        );
    end

    assign x_ptr = ptr_q[0];
    assign y_ptr = ptr_q[1];
    assign z_ptr = ptr_q[2];
endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [1:0]  acc_sel,
    input logic [1:0]  acc_mode,
    input logic [5:0]  acc_disp,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [7:0]  wr_data,
    input logic [15:0] eff_addr,
    input logic [15:0] upd_ptr,
    input logic        acc_illegal,
    input logic [15:0] x_ptr,
    input logic [15:0] y_ptr,
    input logic [15:0] z_ptr
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (x_ptr == 16'd0 && y_ptr == 16'd0 && z_ptr == 16'd0)); // R1

    AST_BYTE_LO_X: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 5'd26 && !acc_valid) |=> (x_ptr[7:0] == $past(wr_data))); // R2

    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'd0 && acc_sel == 2'd1 && !wr_en) |=> $stable(y_ptr)); // R3

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'd1 && !wr_en)
        |=> ($stable(x_ptr) && $stable(y_ptr) && $stable(z_ptr))); // R4

    AST_PREDEC_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd1 && acc_mode == 2'd2 && !wr_en)
        |=> (y_ptr == $past(eff_addr))); // R5

    AST_POSTINC_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd2 && acc_mode == 2'd3 && !wr_en)
        |=> (z_ptr == $past(z_ptr) + 16'd1)); // R6

    AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_illegal && !wr_en)
        |=> ($stable(x_ptr) && $stable(y_ptr) && $stable(z_ptr))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_illegal); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !wr_en)
        |=> ($stable(x_ptr) && $stable(y_ptr) && $stable(z_ptr))); // R8
endmodule

bind ptr_addr_unit ptr_addr_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_sel     (acc_sel),
    .acc_mode    (acc_mode),
    .acc_disp    (acc_disp),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .eff_addr    (eff_addr),
    .upd_ptr     (upd_ptr),
    .acc_illegal (acc_illegal),
    .x_ptr       (x_ptr),
    .y_ptr       (y_ptr),
    .z_ptr       (z_ptr)
);

// File: tb/sim_ptr_addr_unit.sv
`timescale 1ns/1ps
module sim_ptr_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [1:0]  acc_mode = 2'd0;
    logic [5:0]  acc_disp = 6'd0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = 5'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [15:0] eff_addr, upd_ptr, x_ptr, y_ptr, z_ptr;
    logic        acc_illegal;

    always #2.5 clk = ~clk;

    ptr_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_mode(acc_mode), .acc_disp(acc_disp), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .eff_addr(eff_addr), .upd_ptr(upd_ptr),
        .acc_illegal(acc_illegal), .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
    );

    typedef struct packed {
        logic [15:0] x, y, z, eff, upd;
        logic        valid, ill;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    string ptag_q[$];

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [15:0] m [3];
    string last_tag = "R1";

    task automatic check16(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes the expected item, then advances the model
    task automatic drive(bit v, logic [1:0] s, logic [1:0] md, logic [5:0] d,
                         bit we, logic [4:0] wi, logic [7:0] wd, string tag);
        exp_t e;
        logic [15:0] base;
        @(posedge clk);
        #1;
        acc_valid = v; acc_sel = s; acc_mode = md; acc_disp = d;
        wr_en = we; wr_idx = wi; wr_data = wd;
        e.x = m[0]; e.y = m[1]; e.z = m[2];
        e.valid = v; e.ill = 1'b0;
        base = (s == 2'd3) ? 16'd0 : m[s];
        e.eff = base; e.upd = base;
        if (v) begin
            if (s == 2'd3 || (s == 2'd0 && md == 2'd1)) begin
                e.ill = 1'b1; e.eff = 16'd0; e.upd = base;
            end else begin
                case (md)
                    2'd1: e.eff = base + {10'd0, d};
                    2'd2: begin e.eff = base - 16'd1; e.upd = base - 16'd1; end
                    2'd3: e.upd = base + 16'd1;
                    default: ;
                endcase
                if (md >= 2'd2) m[s] = e.upd;
            end
        end
        if (we && wi >= 5'd26) begin
            if (wi[0]) m[(wi - 5'd26) >> 1][15:8] = wd;
            else       m[(wi - 5'd26) >> 1][7:0]  = wd;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ptag_q.push_back(last_tag);
        last_tag = tag;
    endtask

    task automatic wr(logic [4:0] wi, logic [7:0] wd, string tag);
        drive(0, 2'd0, 2'd0, 6'd0, 1, wi, wd, tag);
    endtask

    task automatic acc(logic [1:0] s, logic [1:0] md, logic [5:0] d, string tag);
        drive(1, s, md, d, 0, 5'd0, 8'd0, tag);
    endtask

    // monitor: samples mid-cycle and compares with the popped item
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t, pt;
            e = exp_q.pop_front(); t = tag_q.pop_front(); pt = ptag_q.pop_front();
            check16(pt, "x_ptr", x_ptr, e.x);
            check16(pt, "y_ptr", y_ptr, e.y);
            check16(pt, "z_ptr", z_ptr, e.z);
            check16(e.valid ? t : "R8", "acc_illegal", {15'd0, acc_illegal}, {15'd0, e.ill});
            if (e.valid) begin
                check16(t, "eff_addr", eff_addr, e.eff);
                check16(t, "upd_ptr", upd_ptr, e.upd);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m[i] = 16'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 2'd0, 2'd0, 6'd0, 0, 5'd0, 8'd0, "R1");
        // R2 byte loads
        wr(5'd26, 8'h34, "R2"); wr(5'd27, 8'h12, "R2");
        wr(5'd28, 8'hF0, "R2"); wr(5'd29, 8'h00, "R2");
        wr(5'd30, 8'h00, "R2"); wr(5'd31, 8'h80, "R2");
        wr(5'd25, 8'hFF, "R2"); wr(5'd0, 8'hFF, "R2");
        // R3 plain on each pointer
        acc(2'd0, 2'd0, 6'd0, "R3"); acc(2'd1, 2'd0, 6'd0, "R3"); acc(2'd2, 2'd0, 6'd0, "R3");
        // R4 offset, including max and wrap
        acc(2'd1, 2'd1, 6'd63, "R4"); acc(2'd2, 2'd1, 6'd0, "R4");
        wr(5'd28, 8'hF0, "R4"); wr(5'd29, 8'hFF, "R4");
        acc(2'd1, 2'd1, 6'd32, "R4");
        // R6 increment-after-use on Z, back to back (R8)
        acc(2'd2, 2'd3, 6'd0, "R6"); acc(2'd2, 2'd3, 6'd0, "R8"); acc(2'd2, 2'd3, 6'd0, "R8");
        // R5 decrement-before-use, including wrap at 0
        acc(2'd0, 2'd2, 6'd0, "R5");
        wr(5'd26, 8'h00, "R5"); wr(5'd27, 8'h00, "R5");
        acc(2'd0, 2'd2, 6'd0, "R5");
        acc(2'd0, 2'd3, 6'd0, "R6");
        acc(2'd1, 2'd2, 6'd0, "R5");
        // R7 illegal requests
        acc(2'd0, 2'd1, 6'd5, "R7"); acc(2'd3, 2'd3, 6'd0, "R7"); acc(2'd3, 2'd0, 6'd0, "R7");
        // R8 no strobe, no change
        drive(0, 2'd1, 2'd2, 6'd0, 0, 5'd0, 8'd0, "R8");
        drive(0, 2'd2, 2'd3, 6'd0, 0, 5'd0, 8'd0, "R8");
        // R9 collisions: same pointer, and a different pointer
        drive(1, 2'd1, 2'd3, 6'd0, 1, 5'd28, 8'hAA, "R9");
        drive(1, 2'd2, 2'd2, 6'd0, 1, 5'd31, 8'h5C, "R9");
        drive(1, 2'd0, 2'd3, 6'd0, 1, 5'd30, 8'h77, "R9");
        drive(1, 2'd1, 2'd1, 6'd9, 1, 5'd29, 8'h3E, "R9");
        drive(0, 2'd0, 2'd0, 6'd0, 0, 5'd0, 8'd0, "R9");
        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule